// File: doc/BRIEF.md
# Paged Bus Address Decoder

This block turns a processor bus cycle into select lines. It watches the bus address and two active-low strobes. One strobe marks I/O-space cycles and the other marks boot-memory cycles. From these it produces three kinds of output. The first is a one-hot set of selects for the sectors of two flash arrays, eight large main sectors and four small secondary sectors. The second is a single select for a 256-byte control window in I/O space. The third is three external chip-select pins. Every select is registered, so it appears on the clock edge after the bus inputs that produce it.

An 8-bit page register lives in the control window. Software writes it and reads it back over the same bus. Its low bits enable the external chip selects one by one. Its upper bits form a bank field that has to match a parameter before any external select can fire. Each external pin passes through a polarity bit, so a pin can be active high or active low. All address windows are parameters.

Page register accesses run through a small state machine with three states: `ST_IDLE`, `ST_WRITE` and `ST_READ`.
- `ST_IDLE` goes to `ST_WRITE` on a write hit. This is the only transition that loads the page register.
- Otherwise `ST_IDLE` goes to `ST_READ` on a read hit.
- `ST_WRITE` stays in `ST_WRITE` while the write hit lasts and goes back to `ST_IDLE` when it ends.
- `ST_READ` stays in `ST_READ` while the read hit lasts and goes back to `ST_IDLE` when it ends.

Top module: `pgdec_top`

## Requirements
- R1: With `io_strb_n` low and an address from 02000h to 020FFh, `csr_sel` is 1 on the next clock edge. It is 0 for any other address or strobe.
- R2: With `boot_strb_n` low and an address in [10000h + k·8000h, 18000h + k·8000h) for k = 0..7, `main_sel` equals 1<<k after the next edge. Outside 10000h–4FFFFh, or without the boot strobe, `main_sel` is 0.
- R3: With `boot_strb_n` low and an address in [08000h + k·2000h, 0A000h + k·2000h) for k = 0..3, `sec_sel` equals 1<<k after the next edge. Otherwise it is 0.
- R4: A write hit loads `wdata` into the page register on the edge that leaves `ST_IDLE`. A write hit is `io_strb_n` low, `wr_n` low and address 020E0h. Changes to `wdata` while the same write is held are ignored.
- R5: A read hit drives `rdata` to the page value from the next edge for as long as the read is held. A read hit is `io_strb_n` low, `rd_n` low and address 020E0h. In every other case `rdata` is 00h. A write hit takes priority over a read hit in `ST_IDLE`.
- R6: External select k (k = 0..2) becomes active after the next edge when all of the following hold: `io_strb_n` is low, the address is in [03000h + k·100h, 03100h + k·100h), page bit k is 1, and page bits 7:3 are 0. The decode uses the page value from before that edge.
- R7: External pin k is active high when bit k of the polarity parameter is 1 and active low when it is 0. The default polarity is 010b, so only pin 1 is active high. An inactive pin holds the opposite level.
- R8: At most one of `main_sel`, `sec_sel` and `csr_sel` is 1 at any time.
- R9: Reset clears the page register to 00h and the state to `ST_IDLE`. It also clears all internal selects and `rdata`, and drives each external pin to its inactive level.
- R10: With both strobes high, all internal selects are 0 and every external pin is inactive after the next edge, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Bus address |
| io_strb_n | input | 1 | I/O-space strobe, active low |
| boot_strb_n | input | 1 | Boot-memory strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wdata | input | 8 | Write data for the page register |
| rdata | output | 8 | Page register read-back, 00h when not reading |
| main_sel | output | 8 | Main flash sector selects |
| sec_sel | output | 4 | Secondary flash sector selects |
| csr_sel | output | 1 | Control window select |
| ext_cs | output | 3 | External chip-select pins, polarity applied |

## Verification
The assertions assume that the bus inputs settle between clock edges and hold across each rising edge. They also assume that a single bus cycle never asserts both `wr_n` and `rd_n` at the page address. The memory selects are assumed to be one-hot only because the parameter windows do not overlap. The stimulus changes inputs only on falling edges. It never issues a read and a write together, and it keeps the default windows, which are disjoint.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } acc_state_e;

    // half-open range test [lo, hi)
    function automatic logic in_span(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/pgdec_window.sv
module pgdec_window
    import pgdec_pkg::*;
#(
    parameter int          ADDR_W = 20,
    parameter logic [31:0] BASE   = 32'h0,
    parameter logic [31:0] SPAN   = 32'h100,
    parameter int          COUNT  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              enable,
    output logic [COUNT-1:0]  hit
);

    logic [31:0] addr_w;
    assign addr_w = 32'(addr);

    // one equal-sized slot per output, packed back to back
    generate
        for (genvar gi = 0; gi < COUNT; gi++) begin : g_slot
            localparam logic [31:0] LO = BASE + 32'(gi) * SPAN;
            localparam logic [31:0] HI = LO + SPAN;
            assign hit[gi] = enable && in_span(addr_w, LO, HI);
        end
    endgenerate

endmodule

// File: rtl/pgdec_extcs.sv
module pgdec_extcs
    import pgdec_pkg::*;
#(
    parameter int                       ADDR_W = 20,
    parameter int                       NUM    = 3,
    parameter int                       PAGE_W = 8,
    parameter logic [31:0]              BASE   = 32'h3000,
    parameter logic [31:0]              SPAN   = 32'h100,
    parameter logic [NUM-1:0]           POL    = '0,
    parameter logic [PAGE_W-NUM-1:0]    BANK   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_act,
    input  logic [PAGE_W-1:0] page,
    output logic [NUM-1:0]    pin
);

    logic [NUM-1:0] win;
    logic           bank_ok;

    pgdec_window #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .SPAN   (SPAN),
        .COUNT  (NUM)
    ) u_win (
        .addr   (addr),
        .enable (io_act),
        .hit    (win)
    );

    assign bank_ok = (page[PAGE_W-1:NUM] == BANK);

    // single product term per pin, then the polarity bit
    generate
        for (genvar gk = 0; gk < NUM; gk++) begin : g_pin
            logic term;
            assign term = win[gk] & page[gk] & bank_ok;
            if (POL[gk]) begin : g_high
                assign pin[gk] = term;
            end else begin : g_low
                assign pin[gk] = ~term;
            end
        end
    endgenerate

endmodule

// File: rtl/pgdec_pagereg.sv
module pgdec_pagereg
    import pgdec_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter int          PAGE_W    = 8,
    parameter logic [31:0] PAGE_ADDR = 32'h20E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_act,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic [PAGE_W-1:0] rdata
);

    acc_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic              at_reg, wr_hit, rd_hit, load;

    assign at_reg = (32'(addr) == PAGE_ADDR);
    assign wr_hit = io_act & wr_act & at_reg;
    assign rd_hit = io_act & rd_act & at_reg;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_hit)      state_d = ST_WRITE;
                else if (rd_hit) state_d = ST_READ;
            end
            ST_WRITE: if (!wr_hit) state_d = ST_IDLE;
            ST_READ:  if (!rd_hit) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // the load fires once, on the edge that leaves idle
    assign load = (state_q == ST_IDLE) && (state_d == ST_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= wdata;
    end

    // outputs
    always_comb begin
        page  = page_q;
        rdata = (state_q == ST_READ) ? page_q : '0;
    end

endmodule

// File: rtl/pgdec_top.sv
module pgdec_top
    import pgdec_pkg::*;
#(
    parameter int                          ADDR_W    = 20,
    parameter int                          PAGE_W    = 8,
    parameter int                          MAIN_N    = 8,
    parameter logic [31:0]                 MAIN_BASE = 32'h10000,
    parameter logic [31:0]                 MAIN_SPAN = 32'h8000,
    parameter int                          SEC_N     = 4,
    parameter logic [31:0]                 SEC_BASE  = 32'h08000,
    parameter logic [31:0]                 SEC_SPAN  = 32'h2000,
    parameter logic [31:0]                 CSR_BASE  = 32'h02000,
    parameter logic [31:0]                 CSR_SPAN  = 32'h100,
    parameter logic [31:0]                 PAGE_OFS  = 32'hE0,
    parameter int                          EXT_N     = 3,
    parameter logic [31:0]                 EXT_BASE  = 32'h03000,
    parameter logic [31:0]                 EXT_SPAN  = 32'h100,
    parameter logic [EXT_N-1:0]            EXT_POL   = 3'b010,
    parameter logic [PAGE_W-EXT_N-1:0]     EXT_BANK  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              io_strb_n,
    input  logic              boot_strb_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    output logic [MAIN_N-1:0] main_sel,
    output logic [SEC_N-1:0]  sec_sel,
    output logic              csr_sel,
    output logic [EXT_N-1:0]  ext_cs
);

    localparam logic [31:0] PAGE_ADDR = CSR_BASE + PAGE_OFS;

    logic              io_act, boot_act;
    logic [MAIN_N-1:0] main_hit;
    logic [SEC_N-1:0]  sec_hit;
    logic [0:0]        csr_hit;
    logic [EXT_N-1:0]  ext_pin;
    logic [PAGE_W-1:0] page;

    assign io_act   = ~io_strb_n;
    assign boot_act = ~boot_strb_n;

    pgdec_window #(
        .ADDR_W (ADDR_W), .BASE (MAIN_BASE), .SPAN (MAIN_SPAN), .COUNT (MAIN_N)
    ) u_main (
        .addr (bus_addr), .enable (boot_act), .hit (main_hit)
    );

    pgdec_window #(
        .ADDR_W (ADDR_W), .BASE (SEC_BASE), .SPAN (SEC_SPAN), .COUNT (SEC_N)
    ) u_sec (
        .addr (bus_addr), .enable (boot_act), .hit (sec_hit)
    );

    pgdec_window #(
        .ADDR_W (ADDR_W), .BASE (CSR_BASE), .SPAN (CSR_SPAN), .COUNT (1)
    ) u_csr (
        .addr (bus_addr), .enable (io_act), .hit (csr_hit)
    );

    pgdec_pagereg #(
        .ADDR_W (ADDR_W), .PAGE_W (PAGE_W), .PAGE_ADDR (PAGE_ADDR)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .io_act (io_act),
        .wr_act (~wr_n),
        .rd_act (~rd_n),
        .wdata  (wdata),
        .page   (page),
        .rdata  (rdata)
    );

    pgdec_extcs #(
        .ADDR_W (ADDR_W), .NUM (EXT_N), .PAGE_W (PAGE_W),
        .BASE (EXT_BASE), .SPAN (EXT_SPAN), .POL (EXT_POL), .BANK (EXT_BANK)
    ) u_ext (
        .addr   (bus_addr),
        .io_act (io_act),
        .page   (page),
        .pin    (ext_pin)
    );

    // output register stage: glitch-free selects
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_sel <= '0;
            sec_sel  <= '0;
            csr_sel  <= 1'b0;
            ext_cs   <= ~EXT_POL;
        end else begin
            main_sel <= main_hit;
            sec_sel  <= sec_hit;
            csr_sel  <= csr_hit[0];
            ext_cs   <= ext_pin;
        end
    end

endmodule

// File: rtl/pgdec_chk.sv
module pgdec_chk #(
    parameter int                ADDR_W   = 20,
    parameter int                PAGE_W   = 8,
    parameter int                MAIN_N   = 8,
    parameter int                SEC_N    = 4,
    parameter int                EXT_N    = 3,
    parameter logic [31:0]       CSR_BASE = 32'h02000,
    parameter logic [31:0]       CSR_SPAN = 32'h100,
    parameter logic [EXT_N-1:0]  EXT_POL  = 3'b010
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              io_strb_n,
    input logic              boot_strb_n,
    input logic              rd_n,
    input logic [PAGE_W-1:0] rdata,
    input logic [MAIN_N-1:0] main_sel,
    input logic [SEC_N-1:0]  sec_sel,
    input logic              csr_sel,
    input logic [EXT_N-1:0]  ext_cs
);

    logic             past_ok;
    logic             in_csr;
    logic [EXT_N-1:0] ext_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign in_csr     = (32'(bus_addr) >= CSR_BASE) && (32'(bus_addr) < CSR_BASE + CSR_SPAN);
    assign ext_active = ext_cs ~^ EXT_POL;

    AST_ONE_MEM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({main_sel, sec_sel, csr_sel}) <= 1); // R8

    AST_CSR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!io_strb_n && in_csr) |-> csr_sel); // R1

    AST_CSR_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && csr_sel |-> $past(!io_strb_n)); // R1

    AST_FLASH_NEEDS_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (|{main_sel, sec_sel}) |-> $past(!boot_strb_n)); // R2

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(io_strb_n && boot_strb_n)
        |-> ({main_sel, sec_sel, csr_sel} == '0) && (ext_active == '0)); // R10

    AST_EXT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_active)); // R6

    AST_RDATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (rdata != '0) |-> $past(!rd_n && !io_strb_n)); // R5

endmodule

bind pgdec_top pgdec_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .MAIN_N   (MAIN_N),
    .SEC_N    (SEC_N),
    .EXT_N    (EXT_N),
    .CSR_BASE (CSR_BASE),
    .CSR_SPAN (CSR_SPAN),
    .EXT_POL  (EXT_POL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .io_strb_n   (io_strb_n),
    .boot_strb_n (boot_strb_n),
    .rd_n        (rd_n),
    .rdata       (rdata),
    .main_sel    (main_sel),
    .sec_sel     (sec_sel),
    .csr_sel     (csr_sel),
    .ext_cs      (ext_cs)
);

// File: tb/pgdec_top_bench.sv
`timescale 1ns/1ps
module pgdec_top_bench;

    localparam logic [2:0] POL = 3'b010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        io_strb_n = 1'b1, boot_strb_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, main_sel;
    logic [3:0]  sec_sel;
    logic        csr_sel;
    logic [2:0]  ext_cs;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  m_page  = 8'h00;
    int          m_state = 0;   // 0 idle, 1 write held, 2 read held

    always #2.5 clk = ~clk;

    pgdec_top u_pgdec_top (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr),
        .io_strb_n (io_strb_n), .boot_strb_n (boot_strb_n),
        .wr_n (wr_n), .rd_n (rd_n), .wdata (wdata), .rdata (rdata),
        .main_sel (main_sel), .sec_sel (sec_sel), .csr_sel (csr_sel), .ext_cs (ext_cs)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    // driver: apply one bus cycle, predict the outputs after the next edge
    task automatic drive(input logic [19:0] a, input logic io_n, input logic bt_n,
                         input logic w_n, input logic r_n, input logic [7:0] d,
                         input string tag);
        logic [7:0]  e_main;
        logic [3:0]  e_sec;
        logic        e_csr;
        logic [2:0]  e_ext;
        logic [7:0]  e_rd;
        logic        wh, rh, act;
        logic [31:0] aw;
        int          ns;
        @(negedge clk);
        bus_addr = a; io_strb_n = io_n; boot_strb_n = bt_n;
        wr_n = w_n; rd_n = r_n; wdata = d;
        aw = 32'(a);
        for (int k = 0; k < 8; k++)
            e_main[k] = !bt_n && aw >= 32'h10000 + 32'(k) * 32'h8000
                              && aw <  32'h18000 + 32'(k) * 32'h8000;
        for (int k = 0; k < 4; k++)
            e_sec[k] = !bt_n && aw >= 32'h08000 + 32'(k) * 32'h2000
                             && aw <  32'h0A000 + 32'(k) * 32'h2000;
        e_csr = !io_n && aw >= 32'h2000 && aw <= 32'h20FF;
        for (int k = 0; k < 3; k++) begin
            act = !io_n && aw >= 32'h3000 + 32'(k) * 32'h100
                        && aw <  32'h3100 + 32'(k) * 32'h100
                        && m_page[k] && (m_page[7:3] == 5'd0);
            e_ext[k] = act ? POL[k] : ~POL[k];
        end
        wh = !io_n && !w_n && a == 20'h020E0;
        rh = !io_n && !r_n && a == 20'h020E0;
        case (m_state)
            0: begin
                if (wh) begin ns = 1; m_page = d; end
                else if (rh) ns = 2;
                else ns = 0;
            end
            1: ns = wh ? 1 : 0;
            default: ns = rh ? 2 : 0;
        endcase
        m_state = ns;
        e_rd = (ns == 2) ? m_page : 8'h00;
        exp_q.push_back({e_main, e_sec, e_csr, e_ext, e_rd});
        tag_q.push_back(tag);
    endtask

    task automatic io_cyc(input logic [19:0] a, input logic w_n, input logic r_n,
                          input logic [7:0] d, input string tag);
        drive(a, 1'b0, 1'b1, w_n, r_n, d, tag);
    endtask

    task automatic boot_cyc(input logic [19:0] a, input string tag);
        drive(a, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, tag);
    endtask

    task automatic quiet(input logic [19:0] a, input string tag);
        drive(a, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, tag);
    endtask

    // monitor: compare one result per queued item
    always begin
        logic [23:0] got, e;
        string       t;
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            got = {main_sel, sec_sel, csr_sel, ext_cs, rdata};
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            check(got == e, t, got, e);
            check($countones({main_sel, sec_sel, csr_sel}) <= 1,
                  {"R8 one memory select: ", t}, got, e);
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({main_sel, sec_sel, csr_sel, ext_cs, rdata} == {8'h00, 4'h0, 1'b0, 3'b101, 8'h00},
              "R9 reset state", {main_sel, sec_sel, csr_sel, ext_cs, rdata},
              {8'h00, 4'h0, 1'b0, 3'b101, 8'h00});
        rst_n = 1'b1;

        io_cyc(20'h020E0, 1'b1, 1'b0, 8'h00, "R9 page reads 00h after reset");
        quiet(20'h020E0, "R5 rdata 00h when read ends");

        io_cyc(20'h02000, 1'b1, 1'b1, 8'h00, "R1 window low edge");
        io_cyc(20'h020FF, 1'b1, 1'b1, 8'h00, "R1 window high edge");
        io_cyc(20'h01FFF, 1'b1, 1'b1, 8'h00, "R1 below window");
        io_cyc(20'h02100, 1'b1, 1'b1, 8'h00, "R1 above window");
        boot_cyc(20'h02000, "R1 boot strobe does not open window");

        for (int k = 0; k < 8; k++) begin
            boot_cyc(20'h10000 + 20'(k) * 20'h08000, "R2 main sector first byte");
            boot_cyc(20'h17FFF + 20'(k) * 20'h08000, "R2 main sector last byte");
        end
        boot_cyc(20'h50000, "R2 beyond main array");
        io_cyc(20'h10000, 1'b1, 1'b1, 8'h00, "R2 io strobe does not select flash");

        for (int k = 0; k < 4; k++) begin
            boot_cyc(20'h08000 + 20'(k) * 20'h02000, "R3 secondary sector first byte");
            boot_cyc(20'h09FFF + 20'(k) * 20'h02000, "R3 secondary sector last byte");
        end
        boot_cyc(20'h07FFF, "R3 below secondary array");

        quiet(20'h02000, "R10 no strobe at window");
        quiet(20'h10000, "R10 no strobe at main");
        quiet(20'h08000, "R10 no strobe at secondary");
        quiet(20'h03000, "R10 no strobe at external");

        io_cyc(20'h020E0, 1'b0, 1'b1, 8'h05, "R4 write page 05h");
        io_cyc(20'h020E0, 1'b0, 1'b1, 8'hFF, "R4 held write ignores new data");
        quiet(20'h00000, "R4 write released");
        io_cyc(20'h020E0, 1'b1, 1'b0, 8'h00, "R5 read back page");
        io_cyc(20'h020E0, 1'b1, 1'b0, 8'h00, "R5 held read");
        quiet(20'h00000, "R5 read released");

        io_cyc(20'h03000, 1'b1, 1'b1, 8'h00, "R6 ext0 enabled");
        io_cyc(20'h030FF, 1'b1, 1'b1, 8'h00, "R6 ext0 last byte");
        io_cyc(20'h03100, 1'b1, 1'b1, 8'h00, "R6 ext1 page bit clear");
        io_cyc(20'h03200, 1'b1, 1'b1, 8'h00, "R7 ext2 active low");
        io_cyc(20'h03300, 1'b1, 1'b1, 8'h00, "R6 beyond external windows");

        io_cyc(20'h020E0, 1'b0, 1'b1, 8'h02, "R4 write page 02h");
        quiet(20'h00000, "R4 write released");
        io_cyc(20'h03100, 1'b1, 1'b1, 8'h00, "R7 ext1 active high");
        io_cyc(20'h03000, 1'b1, 1'b1, 8'h00, "R6 ext0 page bit clear");

        io_cyc(20'h020E0, 1'b0, 1'b1, 8'h0D, "R4 write page 0Dh");
        quiet(20'h00000, "R4 write released");
        io_cyc(20'h03000, 1'b1, 1'b1, 8'h00, "R6 bank field nonzero blocks ext0");
        io_cyc(20'h03200, 1'b1, 1'b1, 8'h00, "R6 bank field nonzero blocks ext2");
        io_cyc(20'h020E0, 1'b1, 1'b0, 8'h00, "R5 read back 0Dh");
        quiet(20'h00000, "R10 bus idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule